// File: doc/BRIEF.md
# Instruction Line Fetch Request Controller

This block sits in a multithreaded fetch stage and turns a fetch request for one thread into a read of one whole instruction-cache line. The PC is rounded down to the start of its line and presented to the cache port for one cycle from an output register. The cache answers with `req_ready` in that same cycle. A refused request is parked in one retry slot that all threads share. While the slot is full, no new fetch may issue. A retry pulse from the cache resends the parked request.

Each thread keeps one three-bit wait state and a request tag. Only one request per thread may be in flight. Responses come back with the thread id and tag of the request they answer. A response that does not match the thread's outstanding request, for example one that arrives after a squash, is dropped and counted. A matching response either completes the fetch or parks the thread in a stalled state until its stall input falls. A per-thread squash cancels that thread's outstanding miss and releases the retry slot if that thread owns it.

Top module: `line_fetch_ctrl`

## Requirements
- R1: A request issued with `fetch_pc` = P appears on the port one cycle later: `req_valid`=1, `req_addr` = P with its low log2(LINE_BYTES) bits (6 by default) cleared, `req_tid` = the thread, `req_tag` = that thread's new tag. Without a new issue or resend, `req_valid` is 0 the next cycle.
- R2: `fetch_go` issues nothing in any of these cases: the blocked flag is set, `switched_out` is 1, `irq_pending` is 1 while `phys_mode` is 0, the port register holds a request, or the thread is being squashed.
- R3: If `req_valid`=1 and `req_ready`=0 in a cycle, the owning thread moves to WAIT_RETRY (2). The request is kept in the retry slot and `blocked` is set.
- R4: A `retry_pulse` while the slot is full, the port is idle and the slot owner is not squashed presents the parked address, thread and tag again on the next cycle. If that resend is accepted, the thread moves to WAIT_RSP (3) and `blocked` returns to 0.
- R5: A `retry_pulse` with an empty slot issues no request and leaves `blocked` at 0. A `retry_pulse` while the port register holds a request has no effect.
- R6: A response with `rsp_valid`=1 is dropped, and `drop_count` increments, when its thread is not in WAIT_RSP, its tag differs from that thread's current tag, or its thread is squashed in the same cycle.
- R7: A matching response moves the thread to STALLED (4) if `stall[tid]` is 1. Otherwise the thread moves to DONE (5), and `done_valid`=1 with `done_tid` for that one cycle. DONE returns to RUN (0) on the next cycle. STALLED returns to RUN once `stall` is 0.
- R8: `squash[t]` returns thread t to RUN (0) on the next cycle, overriding a port handshake or response for t. If t owns the retry slot, the slot is emptied and `blocked` is cleared. A later response to the squashed request is dropped.
- R9: Each thread's tag is 0 after reset. It increments by one, modulo 2^TAG_W, on every issue for that thread, so the first request of a thread carries tag 1.
- R10: A thread that is not in RUN (0) cannot issue. A thread with a request in SEND (1), WAIT_RETRY (2) or WAIT_RSP (3) therefore has only one request outstanding.
- R11: After reset every thread is in RUN, `req_valid`=0, `blocked`=0, `done_valid`=0 and `drop_count`=0.

Thread t's state sits at `thr_state[3t+2:3t]`: RUN=0, SEND=1, WAIT_RETRY=2, WAIT_RSP=3, STALLED=4, DONE=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_go | input | 1 | Request a line fetch for `fetch_tid` |
| fetch_tid | input | TID_W | Thread to fetch for |
| fetch_pc | input | ADDR_W | Fetch PC of that thread |
| switched_out | input | 1 | Stage switched out; no issue |
| irq_pending | input | 1 | Interrupt pending |
| phys_mode | input | 1 | Fetch runs in physical/privileged mode |
| stall | input | NTHREADS | Per-thread downstream stall |
| squash | input | NTHREADS | Per-thread squash |
| req_valid | output | 1 | Line request on the cache port |
| req_addr | output | ADDR_W | Line-aligned request address |
| req_tid | output | TID_W | Thread of the request |
| req_tag | output | TAG_W | Tag of the request |
| req_ready | input | 1 | Cache accepts the request this cycle |
| retry_pulse | input | 1 | Cache can take a refused request again |
| rsp_valid | input | 1 | Line response arrives |
| rsp_tid | input | TID_W | Thread of the response |
| rsp_tag | input | TAG_W | Tag of the response |
| thr_state | output | 3*NTHREADS | Per-thread wait state |
| blocked | output | 1 | Cache-blocked flag |
| done_valid | output | 1 | A thread's line fetch completed |
| done_tid | output | TID_W | Thread that completed |
| drop_count | output | DROP_W | Number of dropped responses |

## Verification
The assertions assume that every input is settled and known at each rising edge. They also assume that thread-id inputs name existing threads, so indexing by `req_tid`, `rsp_tid` or the slot owner never goes out of range. The bench drives all inputs on the falling edge. With the default four threads, every two-bit id is a real thread. Random responses draw their tags mostly from the bench's own tag model and sometimes from random values, so both matching and stale responses occur. Squash, retry and refusal are allowed to coincide so that the priority rules are exercised.

// File: rtl/flc_pkg.sv
package flc_pkg;
  typedef enum logic [2:0] {
    TH_RUN    = 3'd0,
    TH_SEND   = 3'd1,
    TH_WRETRY = 3'd2,
    TH_WRSP   = 3'd3,
    TH_STALL  = 3'd4,
    TH_DONE   = 3'd5
  } th_state_e;
endpackage

// File: rtl/flc_thread_fsm.sv
module flc_thread_fsm
  import flc_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             squash_i,
  input  logic             issue_i,
  input  logic             acc_i,
  input  logic             ref_i,
  input  logic             hit_i,
  input  logic             stall_i,
  output th_state_e        state_o,
  output logic [TAG_W-1:0] tag_o
);
  th_state_e        state_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TH_RUN;
      tag_q   <= '0;
    end else begin
      if (issue_i) tag_q <= tag_q + 1'b1;
      if (squash_i) begin
        state_q <= TH_RUN;
      end else if (acc_i) begin
        state_q <= TH_WRSP;
      end else if (ref_i) begin
        state_q <= TH_WRETRY;
      end else begin
        case (state_q)
          TH_RUN:   if (issue_i) state_q <= TH_SEND;
          TH_WRSP:  if (hit_i) state_q <= stall_i ? TH_STALL : TH_DONE;
          TH_STALL: if (!stall_i) state_q <= TH_RUN;
          TH_DONE:  state_q <= TH_RUN;
          default:  state_q <= state_q;
        endcase
      end
    end
  end

  assign state_o = state_q;
  assign tag_o   = tag_q;

  // R8
  squash_to_run_chk: assert property (@(posedge clk) disable iff (rst)
    squash_i |=> state_q == TH_RUN);

  // R9
  tag_step_chk: assert property (@(posedge clk) disable iff (rst)
    issue_i |=> tag_q != $past(tag_q));
endmodule

// File: rtl/flc_port_stage.sv
module flc_port_stage #(
  parameter int NTHREADS = 4,
  parameter int ADDR_W   = 32,
  parameter int TAG_W    = 4,
  parameter int TID_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                issue_i,
  input  logic [TID_W-1:0]    issue_tid_i,
  input  logic [ADDR_W-1:0]   issue_addr_i,
  input  logic [TAG_W-1:0]    issue_tag_i,
  input  logic                req_ready_i,
  input  logic                retry_i,
  input  logic [NTHREADS-1:0] squash_i,
  output logic                req_valid_o,
  output logic [TID_W-1:0]    req_tid_o,
  output logic [ADDR_W-1:0]   req_addr_o,
  output logic [TAG_W-1:0]    req_tag_o,
  output logic                blocked_o,
  output logic                slot_full_o,
  output logic                acc_o,
  output logic                ref_o
);
  logic              req_valid_q;
  logic [TID_W-1:0]  req_tid_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [TAG_W-1:0]  req_tag_q;
  logic              slot_full_q;
  logic [TID_W-1:0]  slot_tid_q;
  logic [ADDR_W-1:0] slot_addr_q;
  logic [TAG_W-1:0]  slot_tag_q;
  logic              blocked_q;

  logic own_sq, slot_sq, resend, acc, refuse;

  always_comb begin
    own_sq  = req_valid_q && squash_i[req_tid_q];
    slot_sq = slot_full_q && squash_i[slot_tid_q];
    acc     = req_valid_q && req_ready_i && !own_sq;
    refuse  = req_valid_q && !req_ready_i && !own_sq;
    resend  = retry_i && slot_full_q && !req_valid_q && !slot_sq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid_q <= 1'b0;
      req_tid_q   <= '0;
      req_addr_q  <= '0;
      req_tag_q   <= '0;
    end else if (issue_i) begin
      req_valid_q <= 1'b1;
      req_tid_q   <= issue_tid_i;
      req_addr_q  <= issue_addr_i;
      req_tag_q   <= issue_tag_i;
    end else if (resend) begin
      req_valid_q <= 1'b1;
      req_tid_q   <= slot_tid_q;
      req_addr_q  <= slot_addr_q;
      req_tag_q   <= slot_tag_q;
    end else begin
      req_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_full_q <= 1'b0;
      slot_tid_q  <= '0;
      slot_addr_q <= '0;
      slot_tag_q  <= '0;
    end else if (refuse) begin
      slot_full_q <= 1'b1;
      slot_tid_q  <= req_tid_q;
      slot_addr_q <= req_addr_q;
      slot_tag_q  <= req_tag_q;
    end else if ((acc && slot_full_q) || slot_sq) begin
      slot_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blocked_q <= 1'b0;
    end else if (refuse) begin
      blocked_q <= 1'b1;
    end else if ((acc && slot_full_q) || (retry_i && !slot_full_q) || slot_sq) begin
      blocked_q <= 1'b0;
    end
  end

  assign req_valid_o = req_valid_q;
  assign req_tid_o   = req_tid_q;
  assign req_addr_o  = req_addr_q;
  assign req_tag_o   = req_tag_q;
  assign blocked_o   = blocked_q;
  assign slot_full_o = slot_full_q;
  assign acc_o       = acc;
  assign ref_o       = refuse;

  // R3
  refuse_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid_q && !req_ready_i && !squash_i[req_tid_q] |=> blocked_q && slot_full_q);

  // R4
  retry_resend_chk: assert property (@(posedge clk) disable iff (rst)
    retry_i && slot_full_q && !req_valid_q && !squash_i[slot_tid_q]
    |=> req_valid_q && req_tid_q == $past(slot_tid_q));

  // R8
  squash_frees_slot_chk: assert property (@(posedge clk) disable iff (rst)
    slot_full_q && squash_i[slot_tid_q] |=> !blocked_q && !slot_full_q);
endmodule

// File: rtl/flc_rsp_filter.sv
module flc_rsp_filter #(
  parameter int NTHREADS = 4,
  parameter int TAG_W    = 4,
  parameter int TID_W    = 2,
  parameter int DROP_W   = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           rsp_valid_i,
  input  logic [TID_W-1:0]               rsp_tid_i,
  input  logic [TAG_W-1:0]               rsp_tag_i,
  input  logic [NTHREADS-1:0]            wait_i,
  input  logic [NTHREADS-1:0][TAG_W-1:0] tags_i,
  input  logic [NTHREADS-1:0]            squash_i,
  input  logic [NTHREADS-1:0]            stall_i,
  output logic [NTHREADS-1:0]            hit_o,
  output logic                           done_valid_o,
  output logic [TID_W-1:0]               done_tid_o,
  output logic [DROP_W-1:0]              drop_o
);
  logic [NTHREADS-1:0] hit;
  logic [DROP_W-1:0]   drop_q;
  logic                done_q;
  logic [TID_W-1:0]    done_tid_q;

  for (genvar t = 0; t < NTHREADS; t++) begin : g_match
    assign hit[t] = rsp_valid_i && (rsp_tid_i == TID_W'(t)) && wait_i[t]
                    && (tags_i[t] == rsp_tag_i) && !squash_i[t];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drop_q     <= '0;
      done_q     <= 1'b0;
      done_tid_q <= '0;
    end else begin
      if (rsp_valid_i && !(|hit)) drop_q <= drop_q + 1'b1;
      done_q     <= |(hit & ~stall_i);
      done_tid_q <= rsp_tid_i;
    end
  end

  assign hit_o        = hit;
  assign done_valid_o = done_q;
  assign done_tid_o   = done_tid_q;
  assign drop_o       = drop_q;

  // R6
  drop_on_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_i && !wait_i[rsp_tid_i] |=> drop_q != $past(drop_q));
endmodule

// File: rtl/line_fetch_ctrl.sv
module line_fetch_ctrl
  import flc_pkg::*;
#(
  parameter int NTHREADS   = 4,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int TAG_W      = 4,
  parameter int DROP_W     = 16,
  localparam int TID_W     = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fetch_go,
  input  logic [TID_W-1:0]      fetch_tid,
  input  logic [ADDR_W-1:0]     fetch_pc,
  input  logic                  switched_out,
  input  logic                  irq_pending,
  input  logic                  phys_mode,
  input  logic [NTHREADS-1:0]   stall,
  input  logic [NTHREADS-1:0]   squash,
  output logic                  req_valid,
  output logic [ADDR_W-1:0]     req_addr,
  output logic [TID_W-1:0]      req_tid,
  output logic [TAG_W-1:0]      req_tag,
  input  logic                  req_ready,
  input  logic                  retry_pulse,
  input  logic                  rsp_valid,
  input  logic [TID_W-1:0]      rsp_tid,
  input  logic [TAG_W-1:0]      rsp_tag,
  output logic [3*NTHREADS-1:0] thr_state,
  output logic                  blocked,
  output logic                  done_valid,
  output logic [TID_W-1:0]      done_tid,
  output logic [DROP_W-1:0]     drop_count
);
  localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

  th_state_e [NTHREADS-1:0]       st;
  logic [NTHREADS-1:0][TAG_W-1:0] tags;
  logic [NTHREADS-1:0]            wait_vec, hit_vec;
  logic                           slot_full, acc, refuse, issue;
  logic [ADDR_W-1:0]              issue_addr;
  logic [TAG_W-1:0]               issue_tag;

  always_comb begin
    issue = fetch_go && (st[fetch_tid] == TH_RUN) && !blocked && !req_valid
            && !switched_out && !(irq_pending && !phys_mode) && !squash[fetch_tid];
    issue_addr = fetch_pc & ~LINE_MASK;
    issue_tag  = tags[fetch_tid] + 1'b1;
  end

  flc_port_stage #(
    .NTHREADS(NTHREADS), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .TID_W(TID_W)
  ) u_port (
    .clk(clk), .rst(rst),
    .issue_i(issue), .issue_tid_i(fetch_tid), .issue_addr_i(issue_addr),
    .issue_tag_i(issue_tag), .req_ready_i(req_ready), .retry_i(retry_pulse),
    .squash_i(squash),
    .req_valid_o(req_valid), .req_tid_o(req_tid), .req_addr_o(req_addr),
    .req_tag_o(req_tag), .blocked_o(blocked), .slot_full_o(slot_full),
    .acc_o(acc), .ref_o(refuse)
  );

  for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
    logic own;
    assign own = req_tid == TID_W'(t);
    flc_thread_fsm #(.TAG_W(TAG_W)) u_fsm (
      .clk(clk), .rst(rst),
      .squash_i(squash[t]),
      .issue_i(issue && (fetch_tid == TID_W'(t))),
      .acc_i(acc && own),
      .ref_i(refuse && own),
      .hit_i(hit_vec[t]),
      .stall_i(stall[t]),
      .state_o(st[t]),
      .tag_o(tags[t])
    );
    assign wait_vec[t]         = st[t] == TH_WRSP;
    assign thr_state[3*t +: 3] = st[t];
  end

  flc_rsp_filter #(
    .NTHREADS(NTHREADS), .TAG_W(TAG_W), .TID_W(TID_W), .DROP_W(DROP_W)
  ) u_rsp (
    .clk(clk), .rst(rst),
    .rsp_valid_i(rsp_valid), .rsp_tid_i(rsp_tid), .rsp_tag_i(rsp_tag),
    .wait_i(wait_vec), .tags_i(tags), .squash_i(squash), .stall_i(stall),
    .hit_o(hit_vec), .done_valid_o(done_valid), .done_tid_o(done_tid),
    .drop_o(drop_count)
  );

  // R2
  switched_out_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    switched_out && !slot_full |=> !req_valid);

  // R7
  done_matches_state_chk: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> st[done_tid] == TH_DONE);

  // R10
  one_inflight_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (st[req_tid] == TH_SEND || st[req_tid] == TH_WRETRY));
endmodule

// File: tb/line_fetch_ctrl_tb.sv
module line_fetch_ctrl_tb;
  localparam int NT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_go = 0, switched_out = 0, irq_pending = 0, phys_mode = 0;
  logic [1:0]  fetch_tid = 0, rsp_tid = 0;
  logic [31:0] fetch_pc = 0;
  logic [3:0]  stall = 0, squash = 0, rsp_tag = 0;
  logic        req_ready = 1, retry_pulse = 0, rsp_valid = 0;
  logic        req_valid, blocked, done_valid;
  logic [31:0] req_addr;
  logic [1:0]  req_tid, done_tid;
  logic [3:0]  req_tag;
  logic [11:0] thr_state;
  logic [15:0] drop_count;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  line_fetch_ctrl u_dut (
    .clk(clk), .rst(rst), .fetch_go(fetch_go), .fetch_tid(fetch_tid),
    .fetch_pc(fetch_pc), .switched_out(switched_out), .irq_pending(irq_pending),
    .phys_mode(phys_mode), .stall(stall), .squash(squash),
    .req_valid(req_valid), .req_addr(req_addr), .req_tid(req_tid),
    .req_tag(req_tag), .req_ready(req_ready), .retry_pulse(retry_pulse),
    .rsp_valid(rsp_valid), .rsp_tid(rsp_tid), .rsp_tag(rsp_tag),
    .thr_state(thr_state), .blocked(blocked), .done_valid(done_valid),
    .done_tid(done_tid), .drop_count(drop_count)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: state codes RUN0 SEND1 WRETRY2 WRSP3 STALL4 DONE5
  int m_st[NT], m_tg[NT];
  bit m_pv, m_sf, m_blk, m_dv;
  int m_ptid, m_ptag, m_stid, m_stag, m_drop, m_dtid;
  longint m_paddr, m_saddr;

  always @(posedge clk) begin : model
    bit iss, own_sq, slot_sq, acc, rfs, hit, resend;
    int n_st[NT];
    if (rst) begin
      for (int t = 0; t < NT; t++) begin m_st[t] = 0; m_tg[t] = 0; end
      m_pv = 0; m_sf = 0; m_blk = 0; m_dv = 0; m_drop = 0;
      m_ptid = 0; m_ptag = 0; m_paddr = 0; m_dtid = 0;
    end else begin
      iss = fetch_go && m_st[fetch_tid] == 0 && !m_blk && !m_pv && !switched_out
            && !(irq_pending && !phys_mode) && !squash[fetch_tid];
      own_sq  = m_pv && squash[m_ptid];
      slot_sq = m_sf && squash[m_stid];
      acc = m_pv && req_ready && !own_sq;
      rfs = m_pv && !req_ready && !own_sq;
      hit = rsp_valid && m_st[rsp_tid] == 3 && m_tg[rsp_tid] == int'(rsp_tag) && !squash[rsp_tid];
      resend = retry_pulse && m_sf && !m_pv && !slot_sq;
      for (int t = 0; t < NT; t++) begin
        n_st[t] = m_st[t];
        if (squash[t]) n_st[t] = 0;
        else if (m_pv && m_ptid == t && acc) n_st[t] = 3;
        else if (m_pv && m_ptid == t && rfs) n_st[t] = 2;
        else if (m_st[t] == 3 && hit && rsp_tid == t) n_st[t] = stall[t] ? 4 : 5;
        else if (m_st[t] == 4 && !stall[t]) n_st[t] = 0;
        else if (m_st[t] == 5) n_st[t] = 0;
        else if (m_st[t] == 0 && iss && fetch_tid == t) n_st[t] = 1;
      end
      if (rsp_valid && !hit) m_drop++;
      m_dv = hit && !stall[rsp_tid];
      m_dtid = rsp_tid;
      if (rfs) m_blk = 1;
      else if ((acc && m_sf) || (retry_pulse && !m_sf) || slot_sq) m_blk = 0;
      if (rfs) begin m_sf = 1; m_stid = m_ptid; m_saddr = m_paddr; m_stag = m_ptag; end
      else if ((acc && m_sf) || slot_sq) m_sf = 0;
      if (iss) begin
        m_tg[fetch_tid] = (m_tg[fetch_tid] + 1) % 16;
        m_pv = 1; m_ptid = fetch_tid; m_ptag = m_tg[fetch_tid];
        m_paddr = longint'(fetch_pc) / 64 * 64;
      end else if (resend) begin
        m_pv = 1; m_ptid = m_stid; m_paddr = m_saddr; m_ptag = m_stag;
      end else m_pv = 0;
      for (int t = 0; t < NT; t++) m_st[t] = n_st[t];
    end
    #2;
    if (!rst && !finished) begin
      chk(req_valid == m_pv, "R1 req_valid", req_valid, m_pv);
      if (m_pv) chk(req_addr == m_paddr && req_tid == m_ptid && req_tag == m_ptag,
                    "R1 req fields", {req_addr, req_tid, req_tag}, {m_paddr[31:0], 2'(m_ptid), 4'(m_ptag)});
      for (int t = 0; t < NT; t++)
        chk(thr_state[3*t +: 3] == m_st[t], "R7 thread state", thr_state[3*t +: 3], m_st[t]);
      chk(blocked == m_blk, "R3 blocked", blocked, m_blk);
      chk(drop_count == m_drop, "R6 drop count", drop_count, m_drop);
      chk(done_valid == m_dv && (!m_dv || done_tid == m_dtid), "R7 done",
          {done_valid, done_tid}, {m_dv, 2'(m_dtid)});
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int stv(int t);
    return int'(thr_state[3*t +: 3]);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    tick();
    chk(req_valid == 0 && blocked == 0 && drop_count == 0 && thr_state == 0 && done_valid == 0,
        "R11 reset", {req_valid, blocked, thr_state}, 0);
    // R1 / R9 first issue
    fetch_go = 1; fetch_tid = 0; fetch_pc = 32'h1234_5678; req_ready = 1;
    tick();
    fetch_go = 0;
    chk(req_valid && req_addr == 32'h1234_5640, "R1 aligned addr", req_addr, 32'h1234_5640);
    chk(req_tag == 1, "R9 first tag", req_tag, 1);
    tick();
    chk(stv(0) == 3, "R4 accepted to WAIT_RSP", stv(0), 3);
    fetch_go = 1; fetch_tid = 0;
    tick();
    chk(req_valid == 0, "R10 no second request", req_valid, 0);
    fetch_go = 0; rsp_valid = 1; rsp_tid = 0; rsp_tag = 5;
    tick();
    chk(drop_count == 1 && stv(0) == 3, "R6 stale tag dropped", drop_count, 1);
    rsp_tag = 1; stall = 4'b0001;
    tick();
    rsp_valid = 0;
    chk(stv(0) == 4 && done_valid == 0, "R7 stalled on response", stv(0), 4);
    tick();
    chk(stv(0) == 4, "R7 stays stalled", stv(0), 4);
    stall = 0;
    tick();
    chk(stv(0) == 0, "R7 stall release", stv(0), 0);
    fetch_go = 1; fetch_tid = 1; fetch_pc = 32'h80;
    tick();
    fetch_go = 0;
    tick();
    rsp_valid = 1; rsp_tid = 1; rsp_tag = 1;
    tick();
    rsp_valid = 0;
    chk(done_valid && done_tid == 1 && stv(1) == 5, "R7 completion", {done_valid, done_tid}, 3'b101);
    tick();
    chk(stv(1) == 0 && !done_valid, "R7 done to run", stv(1), 0);
    // R3 refusal, R2 blocked, R4 retry
    req_ready = 0; fetch_go = 1; fetch_tid = 2; fetch_pc = 32'h1000;
    tick();
    fetch_go = 0;
    tick();
    chk(stv(2) == 2 && blocked && !req_valid, "R3 refused", {stv(2), blocked}, 5);
    fetch_go = 1; fetch_tid = 3; fetch_pc = 32'h2000;
    tick();
    chk(req_valid == 0, "R2 blocked gate", req_valid, 0);
    fetch_go = 0; retry_pulse = 1; req_ready = 1;
    tick();
    retry_pulse = 0;
    chk(req_valid && req_addr == 32'h1000 && req_tid == 2 && req_tag == 1, "R4 resend",
        {req_addr, req_tid, req_tag}, {32'h1000, 2'd2, 4'd1});
    tick();
    chk(stv(2) == 3 && !blocked, "R4 resend accepted", {stv(2), blocked}, 6);
    // R2 interrupt and switch-out gates
    irq_pending = 1; phys_mode = 0; fetch_go = 1; fetch_tid = 3; fetch_pc = 32'h3000;
    tick();
    chk(req_valid == 0, "R2 irq gate", req_valid, 0);
    phys_mode = 1;
    tick();
    chk(req_valid && req_tid == 3, "R2 physical mode issues", req_valid, 1);
    fetch_go = 0; irq_pending = 0; phys_mode = 0;
    tick();
    switched_out = 1; fetch_go = 1; fetch_tid = 0; fetch_pc = 32'h5000;
    tick();
    chk(req_valid == 0, "R2 switched out gate", req_valid, 0);
    switched_out = 0; fetch_go = 0;
    // R8 squash of slot owner, R5 retry on empty slot
    req_ready = 0; fetch_go = 1; fetch_tid = 0; fetch_pc = 32'h4000;
    tick();
    fetch_go = 0;
    chk(req_tag == 2, "R9 tag increments", req_tag, 2);
    tick();
    chk(stv(0) == 2 && blocked, "R3 refused again", blocked, 1);
    squash = 4'b0001;
    tick();
    squash = 0;
    chk(stv(0) == 0 && !blocked, "R8 squash frees slot", {stv(0), blocked}, 0);
    retry_pulse = 1;
    tick();
    retry_pulse = 0;
    chk(!req_valid && !blocked, "R5 empty slot retry", {req_valid, blocked}, 0);
    squash = 4'b0100;
    tick();
    squash = 0;
    chk(stv(2) == 0, "R8 squash outstanding miss", stv(2), 0);
    rsp_valid = 1; rsp_tid = 2; rsp_tag = 1;
    tick();
    rsp_valid = 0;
    chk(drop_count == 2, "R8 late response dropped", drop_count, 2);
    req_ready = 1;
    // random phase, compared against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      fetch_go     = ($urandom % 3) == 0;
      fetch_tid    = 2'($urandom);
      fetch_pc     = $urandom;
      req_ready    = ($urandom % 4) != 0;
      retry_pulse  = ($urandom % 4) == 0;
      rsp_valid    = ($urandom % 3) == 0;
      rsp_tid      = 2'($urandom);
      rsp_tag      = (($urandom % 4) != 0) ? 4'(m_tg[rsp_tid]) : 4'($urandom);
      for (int t = 0; t < NT; t++) squash[t] = ($urandom % 24) == 0;
      stall        = 4'($urandom) & 4'($urandom);
      irq_pending  = ($urandom % 8) == 0;
      phys_mode    = $urandom % 2;
      switched_out = ($urandom % 16) == 0;
      tick();
    end
    fetch_go = 0; rsp_valid = 0; retry_pulse = 0; squash = 0;
    tick();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule